// File: doc/BRIEF.md
# I2C Master Repeated-Start Sequencer

This block produces the Repeated Start condition on an I2C bus for a master. Once a request bit is accepted, it pulls SCL low, lets SDA float high, releases SCL, then pulls SDA low while SCL stays high. SDA is left held low for the byte that follows. Each step waits until the synchronized bus lines confirm the previous one. This means a slave that stretches SCL simply lengthens the sequence. Every timed phase lasts one baud period, which is the reload value plus one system clock cycles.

While the sequence runs, the block refuses writes to the transmit buffer and raises a write-collision flag. Writes to the request bit and to the other master event bits are ignored, so no events can be queued. A watcher on the lines sets a start-seen bit whenever SDA falls while SCL is high. The block flags a bus collision and returns to idle with both lines released in two cases: SDA is low when SCL rises, or SCL drops before the block has pulled SDA low. Sticky flags are cleared with a single strobe.

Top module: `i2c_rstart_seq`

## Requirements
- R1: A write of 1 to the request bit is taken only while no sequence runs, the request bit is clear, and all other event bits are 0. Otherwise the write has no effect, and writes during a sequence leave the request bit unchanged.
- R2: SCL drive goes low one cycle after the request bit reads 1, and in that same cycle SDA drive is released.
- R3: When no slave holds SCL, SCL drive is released R+4 cycles after it was asserted. R is the reload value. This is one baud period of R+1 cycles after SCL is seen low, plus the synchronizer and response latency.
- R4: SDA drive is asserted R+4 cycles after the SCL line actually rises, however long a slave holds SCL low after the block releases it.
- R5: The interrupt flag rises R+1 cycles after SDA drive asserts. In that cycle the request bit clears, SDA drive stays asserted and SCL drive stays released.
- R6: The start-seen bit rises 3 cycles after the SDA line falls while the SCL line is high.
- R7: A buffer write while a sequence runs sets the write-collision flag and leaves the buffer unchanged. This includes the cycle in which the sequence completes. A buffer write at idle stores the data.
- R8: Writes to the event bits are ignored while a sequence runs and are stored at idle.
- R9: If SDA is low when SCL is seen rising, the bus-collision flag is set, both drives are released, the request bit clears and the interrupt flag is not raised.
- R10: If SCL is seen low while both lines should be high before SDA is pulled low, the same collision response as R9 follows.
- R11: The flag-clear strobe zeroes the start-seen, interrupt, write-collision and bus-collision flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reloadVal | input | BRG_W | Baud counter reload value R |
| reqWr | input | 1 | Write strobe for the request bit |
| reqWrData | input | 1 | Value written to the request bit |
| evtReqWr | input | 1 | Write strobe for the other event bits |
| evtReqData | input | EVT_N | Value written to the other event bits |
| bufWr | input | 1 | Transmit buffer write strobe |
| bufWrData | input | BUF_W | Transmit buffer write data |
| clrFlags | input | 1 | Clears the four sticky flags |
| sdaIn | input | 1 | SDA line level, asynchronous |
| sclIn | input | 1 | SCL line level, asynchronous |
| sdaDrvLow | output | 1 | Pull SDA low when 1 |
| sclDrvLow | output | 1 | Pull SCL low when 1 |
| reqBit | output | 1 | Request bit readback |
| evtReq | output | EVT_N | Other event bits readback |
| bufData | output | BUF_W | Transmit buffer contents |
| startSeen | output | 1 | Start pattern observed on the lines |
| intFlag | output | 1 | Sequence completed |
| wcolFlag | output | 1 | Buffer write refused |
| bcolFlag | output | 1 | Bus collision detected |

## Verification
Two functions can coincide in one cycle: the edge on which the final SDA-low period expires and the sequence completes, and a transmit-buffer write. The bench counts R cycles from the rise of SDA drive and places a buffer write on exactly the completion edge. It expects the write to be refused with the write-collision flag set, because the sequence still counts as running on that edge. A second write one idle cycle later must be stored. Request and event-bit writes placed mid-sequence are judged the same way, against the values read back after the write.

// File: rtl/rs_pkg.sv
package rs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GRAB_SCL,
    ST_SDA_HI,
    ST_SCL_UP,
    ST_BOTH_HI,
    ST_SDA_LO
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCnt;
    logic grabScl;
    logic relScl;
    logic relSda;
    logic pullSda;
    logic relBoth;
    logic done;
    logic collide;
  } seqCtl_t;

endpackage

// File: rtl/rs_sync.sv
module rs_sync #(
  parameter int STAGES = 2,
  parameter bit INIT = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[0] <= INIT;
          else       chain[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[i] <= INIT;
          else       chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rs_control.sv
module rs_control
  import rs_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqBit,
  input  logic    sdaS,
  input  logic    sclS,
  input  logic    cntDone,
  output seqCtl_t ctl,
  output logic    seqActive
);
  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;

  always_comb begin
    nextState = state;
    ctl       = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqBit) begin
          ctl.grabScl = 1'b1;
          ctl.relSda  = 1'b1;
          nextState   = ST_GRAB_SCL;
        end
      end
      ST_GRAB_SCL: begin
        if (!sclS) begin
          ctl.loadCnt = 1'b1;
          nextState   = ST_SDA_HI;
        end
      end
      ST_SDA_HI: begin
        if (cntDone && sdaS) begin
          ctl.relScl = 1'b1;
          nextState  = ST_SCL_UP;
        end
      end
      ST_SCL_UP: begin
        if (sclS) begin
          if (!sdaS) begin
            ctl.collide = 1'b1;
            ctl.relBoth = 1'b1;
            nextState   = ST_IDLE;
          end else begin
            ctl.loadCnt = 1'b1;
            nextState   = ST_BOTH_HI;
          end
        end
      end
      ST_BOTH_HI: begin
        if (!sclS) begin
          ctl.collide = 1'b1;
          ctl.relBoth = 1'b1;
          nextState   = ST_IDLE;
        end else if (cntDone) begin
          ctl.pullSda = 1'b1;
          ctl.loadCnt = 1'b1;
          nextState   = ST_SDA_LO;
        end
      end
      ST_SDA_LO: begin
        if (cntDone) begin
          ctl.done  = 1'b1;
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign seqActive = (state != ST_IDLE);
endmodule

// File: rtl/rs_datapath.sv
module rs_datapath
  import rs_pkg::*;
#(
  parameter int BRG_W = 7,
  parameter int EVT_N = 4,
  parameter int BUF_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqCtl_t          ctl,
  input  logic             seqActive,
  input  logic [BRG_W-1:0] reloadVal,
  input  logic             reqWr,
  input  logic             reqWrData,
  input  logic             evtReqWr,
  input  logic [EVT_N-1:0] evtReqData,
  input  logic             bufWr,
  input  logic [BUF_W-1:0] bufWrData,
  input  logic             clrFlags,
  input  logic             sdaIn,
  input  logic             sclIn,
  output logic             sdaS,
  output logic             sclS,
  output logic             cntDone,
  output logic             busy,
  output logic             sdaDrvLow,
  output logic             sclDrvLow,
  output logic             reqBit,
  output logic [EVT_N-1:0] evtReq,
  output logic [BUF_W-1:0] bufData,
  output logic             startSeen,
  output logic             intFlag,
  output logic             wcolFlag,
  output logic             bcolFlag
);
  logic [BRG_W-1:0] baudCnt;
  logic             sdaPrev;
  logic             startPat;

  rs_sync #(.STAGES(SYNC_N), .INIT(1'b1)) u_sdaSync (
    .clk(clk), .rstN(rstN), .din(sdaIn), .dout(sdaS));
  rs_sync #(.STAGES(SYNC_N), .INIT(1'b1)) u_sclSync (
    .clk(clk), .rstN(rstN), .din(sclIn), .dout(sclS));

  assign busy = seqActive | reqBit;

  // baud counter: period = reload + 1 cycles
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                 baudCnt <= '0;
    else if (ctl.loadCnt)      baudCnt <= reloadVal;
    else if (baudCnt != '0)    baudCnt <= baudCnt - 1'b1;

  assign cntDone = (baudCnt == '0);

  // line drivers
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                           sclDrvLow <= 1'b0;
    else if (ctl.relBoth || ctl.relScl)  sclDrvLow <= 1'b0;
    else if (ctl.grabScl)                sclDrvLow <= 1'b1;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                           sdaDrvLow <= 1'b0;
    else if (ctl.relBoth || ctl.relSda)  sdaDrvLow <= 1'b0;
    else if (ctl.pullSda)                sdaDrvLow <= 1'b1;

  // control register bits
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                                    reqBit <= 1'b0;
    else if (ctl.done || ctl.collide)             reqBit <= 1'b0;
    else if (reqWr && !busy && (evtReq == '0))    reqBit <= reqWrData;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                  evtReq <= '0;
    else if (evtReqWr && !busy) evtReq <= evtReqData;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)               bufData <= '0;
    else if (bufWr && !busy) bufData <= bufWrData;

  // start pattern watcher
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) sdaPrev <= 1'b1;
    else       sdaPrev <= sdaS;

  assign startPat = sdaPrev && !sdaS && sclS;

  // sticky flags, set wins over clear
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      startSeen <= 1'b0;
      intFlag   <= 1'b0;
      wcolFlag  <= 1'b0;
      bcolFlag  <= 1'b0;
    end else begin
      if (startPat)          startSeen <= 1'b1;
      else if (clrFlags)     startSeen <= 1'b0;
      if (ctl.done)          intFlag   <= 1'b1;
      else if (clrFlags)     intFlag   <= 1'b0;
      if (bufWr && busy)     wcolFlag  <= 1'b1;
      else if (clrFlags)     wcolFlag  <= 1'b0;
      if (ctl.collide)       bcolFlag  <= 1'b1;
      else if (clrFlags)     bcolFlag  <= 1'b0;
    end
endmodule

// File: rtl/i2c_rstart_seq.sv
module i2c_rstart_seq
  import rs_pkg::*;
#(
  parameter int BRG_W = 7,
  parameter int EVT_N = 4,
  parameter int BUF_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [BRG_W-1:0] reloadVal,
  input  logic             reqWr,
  input  logic             reqWrData,
  input  logic             evtReqWr,
  input  logic [EVT_N-1:0] evtReqData,
  input  logic             bufWr,
  input  logic [BUF_W-1:0] bufWrData,
  input  logic             clrFlags,
  input  logic             sdaIn,
  input  logic             sclIn,
  output logic             sdaDrvLow,
  output logic             sclDrvLow,
  output logic             reqBit,
  output logic [EVT_N-1:0] evtReq,
  output logic [BUF_W-1:0] bufData,
  output logic             startSeen,
  output logic             intFlag,
  output logic             wcolFlag,
  output logic             bcolFlag
);
  localparam int SYNC_N = 2;

  seqCtl_t ctl;
  logic    seqActive;
  logic    sdaS, sclS, cntDone, busy;

  rs_control u_ctrl (
    .clk(clk), .rstN(rstN), .reqBit(reqBit), .sdaS(sdaS), .sclS(sclS),
    .cntDone(cntDone), .ctl(ctl), .seqActive(seqActive));

  rs_datapath #(
    .BRG_W(BRG_W), .EVT_N(EVT_N), .BUF_W(BUF_W), .SYNC_N(SYNC_N)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .seqActive(seqActive),
    .reloadVal(reloadVal), .reqWr(reqWr), .reqWrData(reqWrData),
    .evtReqWr(evtReqWr), .evtReqData(evtReqData), .bufWr(bufWr),
    .bufWrData(bufWrData), .clrFlags(clrFlags), .sdaIn(sdaIn), .sclIn(sclIn),
    .sdaS(sdaS), .sclS(sclS), .cntDone(cntDone), .busy(busy),
    .sdaDrvLow(sdaDrvLow), .sclDrvLow(sclDrvLow), .reqBit(reqBit),
    .evtReq(evtReq), .bufData(bufData), .startSeen(startSeen),
    .intFlag(intFlag), .wcolFlag(wcolFlag), .bcolFlag(bcolFlag));
endmodule

// File: rtl/i2c_rstart_seq_chk.sv
module i2c_rstart_seq_chk #(
  parameter int EVT_N = 4,
  parameter int BUF_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             bufWr,
  input logic [BUF_W-1:0] bufData,
  input logic             wcolFlag,
  input logic [EVT_N-1:0] evtReq,
  input logic             intFlag,
  input logic             bcolFlag,
  input logic             sdaDrvLow,
  input logic             sclDrvLow,
  input logic             reqBit
);
  // R1
  req_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqBit) |-> ($past(evtReq) == '0) && !$past(busy));

  // R2
  grab_scl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclDrvLow) |-> $past(reqBit) && !sdaDrvLow);

  // R5
  done_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intFlag) |-> sdaDrvLow && !sclDrvLow && !reqBit);

  // R7
  buf_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bufWr && busy) |=> $stable(bufData) && wcolFlag);

  // R8
  evt_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(evtReq));

  // R9
  collide_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bcolFlag) |-> !sdaDrvLow && !sclDrvLow && !reqBit);
endmodule

bind i2c_rstart_seq i2c_rstart_seq_chk #(.EVT_N(EVT_N), .BUF_W(BUF_W)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .bufWr(bufWr), .bufData(bufData),
  .wcolFlag(wcolFlag), .evtReq(evtReq), .intFlag(intFlag),
  .bcolFlag(bcolFlag), .sdaDrvLow(sdaDrvLow), .sclDrvLow(sclDrvLow),
  .reqBit(reqBit));

// File: tb/i2c_rstart_seq_test.sv
module i2c_rstart_seq_test;
  localparam int BW = 7;
  localparam int EN = 4;
  localparam int DW = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rstN;
  logic [BW-1:0] reloadVal;
  logic          reqWr, reqWrData, evtReqWr, bufWr, clrFlags;
  logic [EN-1:0] evtReqData, evtReq;
  logic [DW-1:0] bufWrData, bufData;
  logic          sdaIn, sclIn, sdaDrvLow, sclDrvLow, reqBit;
  logic          startSeen, intFlag, wcolFlag, bcolFlag;
  logic          slvSda = 1'b0, slvScl = 1'b0;

  assign sdaIn = !(sdaDrvLow || slvSda);
  assign sclIn = !(sclDrvLow || slvScl);

  i2c_rstart_seq #(.BRG_W(BW), .EVT_N(EN), .BUF_W(DW)) uut (
    .clk(clk), .rstN(rstN), .reloadVal(reloadVal), .reqWr(reqWr),
    .reqWrData(reqWrData), .evtReqWr(evtReqWr), .evtReqData(evtReqData),
    .bufWr(bufWr), .bufWrData(bufWrData), .clrFlags(clrFlags),
    .sdaIn(sdaIn), .sclIn(sclIn), .sdaDrvLow(sdaDrvLow),
    .sclDrvLow(sclDrvLow), .reqBit(reqBit), .evtReq(evtReq),
    .bufData(bufData), .startSeen(startSeen), .intFlag(intFlag),
    .wcolFlag(wcolFlag), .bcolFlag(bcolFlag));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0;
  int bad = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic clearFlags();
    clrFlags = 1'b1;
    @(negedge clk);
    clrFlags = 1'b0;
  endtask

  task automatic request(output int w);
    reqWr = 1'b1; reqWrData = 1'b1;
    @(negedge clk);
    reqWr = 1'b0;
    w = cyc;
  endtask

  // mode 0 plain, 1 buffer write on completion edge, 2 writes mid-sequence
  task automatic runSeq(input int r, input int s, input int mode);
    int w, tGrab, tRel, tLow, tStart, tInt;
    logic pScl, pSda;
    logic [DW-1:0] bufBefore;
    reloadVal = BW'(r);
    clearFlags();
    bufBefore = bufData;
    pScl = sclDrvLow; pSda = sdaDrvLow;
    request(w);
    chk("R1", "request accepted", int'(reqBit), 1);
    tGrab = -1; tRel = -1; tLow = -1; tStart = -1; tInt = -1;
    for (int k = 0; k < 400 && (tInt < 0 || tStart < 0); k++) begin
      @(negedge clk);
      if (slvScl && cyc == tRel + s) slvScl = 1'b0;
      if (sclDrvLow && !pScl && tGrab < 0) tGrab = cyc;
      if (!sclDrvLow && pScl && tRel < 0) begin
        tRel = cyc;
        if (s > 0) slvScl = 1'b1;
      end
      if (sdaDrvLow && !pSda && tLow < 0) tLow = cyc;
      if (startSeen && tStart < 0) tStart = cyc;
      if (intFlag && tInt < 0) tInt = cyc;
      if (mode == 1 && tLow >= 0 && cyc == tLow + r) begin
        bufWr = 1'b1; bufWrData = ~bufBefore;
      end else bufWr = 1'b0;
      if (mode == 2 && cyc == w + 2) begin
        evtReqWr = 1'b1; evtReqData = 4'b0011;
        reqWr = 1'b1; reqWrData = 1'b0;
      end else begin
        evtReqWr = 1'b0; reqWr = 1'b0;
      end
      if (mode == 2 && cyc == w + 3) begin
        chk("R8", "event write ignored while busy", int'(evtReq), 0);
        chk("R1", "request write ignored while busy", int'(reqBit), 1);
      end
      pScl = sclDrvLow; pSda = sdaDrvLow;
    end
    chk("R2", "SCL grab cycle", tGrab, w + 1);
    chk("R3", "SCL release cycle", tRel, tGrab + r + 4);
    chk("R4", "SDA pull cycle after SCL rise", tLow, tRel + s + r + 4);
    chk("R5", "interrupt cycle", tInt, tLow + r + 1);
    chk("R6", "start seen cycle", tStart, tLow + 3);
    chk("R5", "SDA held low", int'(sdaDrvLow), 1);
    chk("R5", "SCL released", int'(sclDrvLow), 0);
    chk("R5", "request cleared", int'(reqBit), 0);
    if (mode == 1) begin
      chk("R7", "wcol on completion edge", int'(wcolFlag), 1);
      chk("R7", "buffer kept", int'(bufData), int'(bufBefore));
      bufWr = 1'b1; bufWrData = 8'h5C;
      @(negedge clk);
      bufWr = 1'b0;
      chk("R7", "idle buffer write", int'(bufData), 8'h5C);
    end
  endtask

  // mode 0: SDA low at SCL rise; mode 1: SCL low during both-high
  task automatic runCol(input int mode);
    int w, tRel;
    logic pScl;
    reloadVal = BW'(10);
    clearFlags();
    pScl = sclDrvLow;
    request(w);
    tRel = -1;
    for (int k = 0; k < 100 && tRel < 0; k++) begin
      @(negedge clk);
      if (!sclDrvLow && pScl) tRel = cyc;
      pScl = sclDrvLow;
    end
    if (mode == 0) slvSda = 1'b1;
    else begin
      repeat (4) @(negedge clk);
      slvScl = 1'b1;
    end
    repeat (8) @(negedge clk);
    chk(mode == 0 ? "R9" : "R10", "bus collision flag", int'(bcolFlag), 1);
    chk(mode == 0 ? "R9" : "R10", "SDA released", int'(sdaDrvLow), 0);
    chk(mode == 0 ? "R9" : "R10", "SCL released", int'(sclDrvLow), 0);
    chk(mode == 0 ? "R9" : "R10", "request cleared", int'(reqBit), 0);
    chk(mode == 0 ? "R9" : "R10", "no interrupt", int'(intFlag), 0);
    slvSda = 1'b0; slvScl = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; reloadVal = '0; reqWr = 1'b0; reqWrData = 1'b0;
    evtReqWr = 1'b0; evtReqData = '0; bufWr = 1'b0; bufWrData = '0;
    clrFlags = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R2", "reset SCL drive", int'(sclDrvLow), 0);
    chk("R2", "reset SDA drive", int'(sdaDrvLow), 0);
    chk("R1", "reset request", int'(reqBit), 0);
    chk("R11", "reset flags", int'({startSeen, intFlag, wcolFlag, bcolFlag}), 0);
    chk("R7", "reset buffer", int'(bufData), 0);

    // R8 idle event write stored, R1 request blocked by pending event
    evtReqWr = 1'b1; evtReqData = 4'b0100;
    @(negedge clk);
    evtReqWr = 1'b0;
    chk("R8", "idle event write", int'(evtReq), 4);
    reqWr = 1'b1; reqWrData = 1'b1;
    @(negedge clk);
    reqWr = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1", "request blocked by event", int'(reqBit), 0);
    chk("R1", "no SCL grab when blocked", int'(sclDrvLow), 0);
    evtReqWr = 1'b1; evtReqData = '0;
    @(negedge clk);
    evtReqWr = 1'b0;

    for (int r = 0; r < 8; r++) runSeq(r, 0, 0);
    for (int s = 1; s < 5; s++) runSeq(3, s, 0);
    runSeq(2, 0, 1);
    runSeq(4, 0, 2);
    runSeq(0, 0, 1);
    runCol(0);
    runCol(1);
    runSeq(1, 0, 0);

    // R11 flag clear after flags were set
    bufWr = 1'b1; reqWr = 1'b1; reqWrData = 1'b1;
    @(negedge clk);
    bufWr = 1'b0; reqWr = 1'b0;
    @(negedge clk);
    bufWr = 1'b1;
    @(negedge clk);
    bufWr = 1'b0;
    repeat (30) @(negedge clk);
    chk("R11", "flags set before clear", int'({startSeen, intFlag, wcolFlag}), 7);
    clearFlags();
    chk("R11", "flags cleared", int'({startSeen, intFlag, wcolFlag, bcolFlag}), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule